// File: doc/BRIEF.md
# USB Endpoint Interrupt Request Register

This block holds one sticky interrupt request bit for each of seven USB device endpoints of mixed transfer types. On every clock edge each endpoint position looks at the status conditions that belong to its type. Those conditions are packet ready, receive overflow, isochronous error, packet complete and transmit underrun. If the endpoint's mask bit is low and any of its conditions is high, the request bit is set.

A set request stays pending until software writes a one to that bit position. The pending bits can be read back at any time. One combined interrupt line is high whenever any bit is pending.

The mapping from position to endpoint type is a parameter. Each position uses a 2-bit code: 0 is isochronous OUT, 1 is bulk/interrupt IN, 2 is bulk OUT and 3 is isochronous IN. By default, position 0 and position 5 are isochronous OUT. Positions 1, 2 and 6 are bulk/interrupt IN. Position 3 is bulk OUT and position 4 is isochronous IN. All status, mask, write and read vectors use bit i for position i.

The status inputs and mask are plain levels. The register port is a single-cycle write strobe with no handshake, so it has no back-pressure.

Top module: `usb_ep_irq_reg`

## Requirements
- R1: After reset, every pending bit (rd_data) is 0 and irq is 0.
- R2: While mask[i] is 1, pending bit i is never newly set, whatever its status inputs are.
- R3: An isochronous OUT position (positions 0 and 5 by default) sets its bit when any of these is high: pkt_rdy[i], rx_ovf[i] or iso_err[i]. It ignores pkt_done[i] and tx_undr[i].
- R4: A bulk/interrupt IN position (positions 1, 2 and 6) sets its bit only from pkt_done[i].
- R5: A bulk OUT position (position 3) sets its bit only from pkt_rdy[i].
- R6: An isochronous IN position (position 4) sets its bit from pkt_done[i] or tx_undr[i].
- R7: A cycle with wr_en high clears every pending bit whose wr_data bit is 1. Bits written 0 keep their value, and each bit clears independently of the others.
- R8: When a bit's unmasked set condition and its write-one clear occur in the same cycle, the bit is 1 afterwards.
- R9: Raising mask[i] while bit i is pending does not clear bit i.
- R10: irq is 1 exactly when at least one pending bit is 1. It follows rd_data with no added delay.
- R11: A condition held high is re-sampled every cycle. One cycle after its mask drops to 0, a cleared bit is pending again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_rdy | input | 7 | OUT packet ready, one bit per position |
| rx_ovf | input | 7 | Receive overflow, one bit per position |
| iso_err | input | 7 | Isochronous error flag, one bit per position |
| pkt_done | input | 7 | IN packet complete, one bit per position |
| tx_undr | input | 7 | Transmit underrun, one bit per position |
| mask | input | 7 | Per-position request mask (1 blocks new sets) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 7 | Write-one-to-clear data |
| rd_data | output | 7 | Pending request bits |
| irq | output | 1 | OR of all pending bits |

## Verification
A wrong source decode or a wrong type map shows up on rd_data exactly one clock after a single-source pulse. At that point either the wrong position is set, or the expected position is not set. A fault in the clear or priority logic shows up on the edge after the write: a bit is lost, a bit survives, or a neighbouring bit is disturbed. Because irq is derived straight from the pending bits, any disagreement between irq and rd_data is visible in the same cycle.

// File: rtl/usb_ep_irq_pkg.sv
package usb_ep_irq_pkg;
  typedef enum logic [1:0] {
    EP_ISO_OUT  = 2'd0,
    EP_BULK_IN  = 2'd1,
    EP_BULK_OUT = 2'd2,
    EP_ISO_IN   = 2'd3
  } ep_kind_e;

  typedef struct packed {
    logic rdy;
    logic ovf;
    logic ierr;
    logic done;
    logic undr;
  } ep_src_t;

  localparam int KIND_W = 2;
endpackage

// File: rtl/ep_set_decode.sv
module ep_set_decode
  import usb_ep_irq_pkg::*;
#(
  parameter logic [KIND_W-1:0] KIND = EP_ISO_OUT
) (
  input  ep_src_t src,
  output logic    set_raw
);
  generate
    if (KIND == EP_ISO_OUT) begin : g_iso_out
      assign set_raw = src.rdy | src.ovf | src.ierr;
    end else if (KIND == EP_BULK_IN) begin : g_bulk_in
      assign set_raw = src.done;
    end else if (KIND == EP_BULK_OUT) begin : g_bulk_out
      assign set_raw = src.rdy;
    end else begin : g_iso_in
      assign set_raw = src.done | src.undr;
    end
  endgenerate
endmodule

// File: rtl/ep_req_bit.sv
module ep_req_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_raw,
  input  logic masked,
  input  logic clr,
  output logic pend
);
  logic set_ok;
  assign set_ok = set_raw & ~masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend <= 1'b0;
    else if (set_ok) pend <= 1'b1;
    else if (clr)    pend <= 1'b0;
  end
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int N = 7
) (
  input  logic [N-1:0] pend,
  output logic         irq
);
  assign irq = |pend;
endmodule

// File: rtl/usb_ep_irq_reg.sv
module usb_ep_irq_reg
  import usb_ep_irq_pkg::*;
#(
  parameter int NUM_EP = 7,
  parameter logic [NUM_EP*KIND_W-1:0] EP_KINDS = 14'b01_00_11_10_01_01_00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] pkt_rdy,
  input  logic [NUM_EP-1:0] rx_ovf,
  input  logic [NUM_EP-1:0] iso_err,
  input  logic [NUM_EP-1:0] pkt_done,
  input  logic [NUM_EP-1:0] tx_undr,
  input  logic [NUM_EP-1:0] mask,
  input  logic              wr_en,
  input  logic [NUM_EP-1:0] wr_data,
  output logic [NUM_EP-1:0] rd_data,
  output logic              irq
);
  logic [NUM_EP-1:0] clr_vec;
  logic [NUM_EP-1:0] set_vec;

  assign clr_vec = wr_en ? wr_data : '0;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    ep_src_t src;
    assign src = '{rdy: pkt_rdy[i], ovf: rx_ovf[i], ierr: iso_err[i],
                   done: pkt_done[i], undr: tx_undr[i]};

    ep_set_decode #(.KIND(EP_KINDS[i*KIND_W +: KIND_W])) u_dec (
      .src     (src),
      .set_raw (set_vec[i])
    );

    ep_req_bit u_bit (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_raw (set_vec[i]),
      .masked  (mask[i]),
      .clr     (clr_vec[i]),
      .pend    (rd_data[i])
    );
  end

  irq_combine #(.N(NUM_EP)) u_or (
    .pend (rd_data),
    .irq  (irq)
  );
endmodule

// File: rtl/usb_ep_irq_chk.sv
module usb_ep_irq_chk
  import usb_ep_irq_pkg::*;
#(
  parameter int NUM_EP = 7,
  parameter logic [NUM_EP*KIND_W-1:0] EP_KINDS = 14'b01_00_11_10_01_01_00
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_EP-1:0] pkt_rdy,
  input logic [NUM_EP-1:0] rx_ovf,
  input logic [NUM_EP-1:0] iso_err,
  input logic [NUM_EP-1:0] pkt_done,
  input logic [NUM_EP-1:0] tx_undr,
  input logic [NUM_EP-1:0] mask,
  input logic              wr_en,
  input logic [NUM_EP-1:0] wr_data,
  input logic [NUM_EP-1:0] rd_data,
  input logic              irq
);
  logic [NUM_EP-1:0] want;
  always_comb begin
    for (int i = 0; i < NUM_EP; i++) begin
      unique case (EP_KINDS[i*KIND_W +: KIND_W])
        2'd0:    want[i] = pkt_rdy[i] | rx_ovf[i] | iso_err[i];
        2'd1:    want[i] = pkt_done[i];
        2'd2:    want[i] = pkt_rdy[i];
        default: want[i] = pkt_done[i] | tx_undr[i];
      endcase
    end
  end

  // R2
  masked_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data & ~$past(rd_data) & $past(mask)) == '0));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(want & ~mask)) & ~rd_data) == '0));

  // R7
  no_fall_unwritten_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~rd_data & $past(rd_data) & ~$past(wr_en ? wr_data : '0)) == '0));

  // R10
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data == '0) |-> !irq);

  // R10
  irq_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data != '0) |-> irq);
endmodule

bind usb_ep_irq_reg usb_ep_irq_chk #(.NUM_EP(NUM_EP), .EP_KINDS(EP_KINDS)) u_chk (.*);

// File: tb/usb_ep_irq_reg_bench.sv
module usb_ep_irq_reg_bench;
  localparam int N = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pkt_rdy = '0, rx_ovf = '0, iso_err = '0, pkt_done = '0, tx_undr = '0;
  logic [N-1:0] mask = '0, wr_data = '0;
  logic wr_en = 1'b0;
  logic [N-1:0] rd_data;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  usb_ep_irq_reg u_usb_ep_irq_reg (.*);

  // Position type codes, written down from the requirements: 0 iso OUT, 1 bulk IN, 2 bulk OUT, 3 iso IN
  function automatic int kind_of(int p);
    case (p)
      0, 5:    return 0;
      1, 2, 6: return 1;
      3:       return 2;
      default: return 3;
    endcase
  endfunction

  // combo bits: 0 rdy, 1 ovf, 2 ierr, 3 done, 4 undr
  function automatic bit expect_set(int p, int c);
    case (kind_of(p))
      0:       return c[0] | c[1] | c[2];
      1:       return c[3];
      2:       return c[0];
      default: return c[3] | c[4];
    endcase
  endfunction

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp, logic irq_exp);
    checks++;
    if (act !== exp || irq !== irq_exp) begin
      fails++;
      $display("FAIL %s: rd_data=%b irq=%b expected rd_data=%b irq=%b", req, act, irq, exp, irq_exp);
    end
  endtask

  task automatic clear_src();
    pkt_rdy = '0; rx_ovf = '0; iso_err = '0; pkt_done = '0; tx_undr = '0;
  endtask

  // drive at negedge, one posedge, back to negedge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wipe();
    clear_src(); mask = '0; wr_en = 1'b1; wr_data = '1;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: rd_data=%b expected completion", rd_data);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1", rd_data, '0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", rd_data, '0, 1'b0);

    // Sweep: every position, every source combination, mask on and off
    for (int p = 0; p < N; p++) begin
      for (int c = 0; c < 32; c++) begin
        for (int m = 0; m < 2; m++) begin
          logic [N-1:0] e;
          string tag;
          wipe();
          pkt_rdy[p] = c[0]; rx_ovf[p] = c[1]; iso_err[p] = c[2];
          pkt_done[p] = c[3]; tx_undr[p] = c[4];
          mask[p] = m[0];
          tick();
          e = '0;
          e[p] = expect_set(p, c) & (m == 0);
          if (m == 1) tag = "R2";
          else case (kind_of(p))
            0: tag = "R3";
            1: tag = "R4";
            2: tag = "R5";
            default: tag = "R6";
          endcase
          chk(tag, rd_data, e, |e);
        end
      end
    end

    // R7: set all, clear a pattern, zeros untouched
    wipe();
    pkt_rdy = '1; pkt_done = '1;
    tick();
    clear_src();
    chk("R7", rd_data, 7'h7f, 1'b1);
    wr_en = 1'b1; wr_data = 7'b0101010;
    tick();
    wr_en = 1'b0;
    chk("R7", rd_data, 7'b1010101, 1'b1);
    wr_en = 1'b1; wr_data = 7'b0000000;
    tick();
    wr_en = 1'b0;
    chk("R7", rd_data, 7'b1010101, 1'b1);
    wr_en = 1'b0; wr_data = 7'b1111111;
    tick();
    chk("R7", rd_data, 7'b1010101, 1'b1);
    wr_en = 1'b1; wr_data = 7'b1010101;
    tick();
    wr_en = 1'b0; wr_data = '0;
    chk("R10", rd_data, 7'b0000000, 1'b0);

    // R8: set and clear collide at position 3 (bulk OUT), clear alone at position 1
    wipe();
    pkt_done[1] = 1'b1;
    tick();
    clear_src();
    pkt_rdy[3] = 1'b1; wr_en = 1'b1; wr_data = 7'b0001010;
    tick();
    clear_src(); wr_en = 1'b0;
    chk("R8", rd_data, 7'b0001000, 1'b1);

    // R9: mask raised while pending keeps the bit
    wipe();
    tx_undr[4] = 1'b1;
    tick();
    clear_src(); mask[4] = 1'b1;
    tick();
    tick();
    chk("R9", rd_data, 7'b0010000, 1'b1);

    // R11: held condition, masked then cleared, returns one cycle after unmask
    wipe();
    iso_err[5] = 1'b1; mask[5] = 1'b1;
    tick();
    chk("R11", rd_data, '0, 1'b0);
    mask[5] = 1'b0;
    tick();
    chk("R11", rd_data, 7'b0100000, 1'b1);
    mask[5] = 1'b1; wr_en = 1'b1; wr_data = 7'b0100000;
    tick();
    wr_en = 1'b0; wr_data = '0;
    chk("R11", rd_data, '0, 1'b0);
    mask[5] = 1'b0;
    chk("R11", rd_data, '0, 1'b0);
    tick();
    chk("R11", rd_data, 7'b0100000, 1'b1);

    // R1: reset in the middle clears pending state
    rst_n = 1'b0;
    #1;
    chk("R1", rd_data, '0, 1'b0);
    clear_src();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", rd_data, '0, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule